// File: doc/BRIEF.md
# Chroma Automatic Gain Loop

This block sets the level of a signed chroma sample stream so that the colour burst settles near a programmable target. Each line it finds the burst amplitude, which is the largest absolute sample value seen while the burst window is open. At the end-of-line strobe it compares that amplitude with the target and moves a shared gain one code up or down. A manual override replaces the loop gain with a register value and freezes the loop. After the shared gain, a second stage applies an independent trim to U samples and to V samples. The input may be filtered or raw chroma; the block treats both the same way.

Samples enter with a valid qualifier and a U/V tag. Both tags take part in the burst measurement. Every valid sample leaves through a two-stage multiply pipeline, where it is rounded and clipped to the input width. The current effective gain is visible on its own output.

Top module: `chroma_gain_loop`

## Requirements
- R1: After reset, `gain_out` is 64 (unity gain, 6 fractional bits) and `out_valid` is 0.
- R2: The burst amplitude is the largest absolute value among valid samples taken while `burst_gate` is high. Both signs count. It restarts from the first sample of each new gate window, and a window that opens without a valid sample starts from 0.
- R3: On `line_end` in automatic mode, after a line that held at least one gated valid sample, the loop gain rises by one code if amplitude + 2 < target and falls by one code if amplitude > target + 2. A line never moves the gain by more than one code.
- R4: When the amplitude is within 2 codes of the target, inclusive, the gain does not change.
- R5: The loop gain saturates at 255 at the top and at 16 at the bottom.
- R6: A line with no gated valid sample leaves the gain unchanged.
- R7: While `manual_en` is 1, `gain_out` equals `manual_gain`, samples are scaled by it, and the loop gain is frozen. When `manual_en` returns to 0, the loop resumes from its frozen value.
- R8: A `target_level` of 0 selects the built-in target of 112, which is the 40 IRE burst code. Any other value is used as the target directly.
- R9: Each valid sample x comes out two cycles later as y = clip(round(clip(round(x*g/64))*t/64)). Here g is the effective gain and t is `trim_u` when `in_is_v` = 0 or `trim_v` when `in_is_v` = 1. Rounding adds 32 and then shifts right arithmetically by 6. `out_is_v` carries the tag.
- R10: Each clip stage limits its result to the range -512..511.
- R11: A gated sample that arrives in the same cycle as `line_end` belongs to the next line. The decision in that cycle uses the amplitude and burst-seen state from before that sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample qualifier |
| in_is_v | input | 1 | Tag: 0 = U sample, 1 = V sample |
| chroma_in | input | 10 | Signed chroma sample |
| burst_gate | input | 1 | High during the burst window |
| line_end | input | 1 | One-cycle end-of-line strobe |
| manual_en | input | 1 | 1 selects the manual gain |
| manual_gain | input | 8 | Manual gain, 6 fractional bits |
| target_level | input | 10 | Burst target (0 selects the default) |
| trim_u | input | 8 | U trim, 6 fractional bits |
| trim_v | input | 8 | V trim, 6 fractional bits |
| out_valid | output | 1 | Output qualifier |
| out_is_v | output | 1 | Tag of the output sample |
| chroma_out | output | 10 | Scaled signed chroma |
| gain_out | output | 8 | Effective gain |

## Verification
Two events can land in the same cycle: the end-of-line gain decision and a burst sample, either the one that opens a new gate window or one that extends the current window. The bench provokes this by asserting `line_end` on the cycle where a new burst window opens with a large sample. The expected result is that the decision still uses the earlier, smaller amplitude. On the following line the large sample must drive the gain down again. Gain values are checked as literal codes after each line, while the scaled samples are checked through a scoreboard.

// File: rtl/chroma_gain_pkg.sv
package chroma_gain_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_UP   = 2'd1,
      STEP_DOWN = 2'd2
   } gain_step_e;
endpackage

// File: rtl/burst_peak_meter.sv
module burst_peak_meter #(
   parameter int DW = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic signed [DW-1:0] sample_i,
   input  logic                 gate_i,
   input  logic                 eol_i,
   output logic [DW-1:0]        peak_o,
   output logic                 seen_o
);
   logic          gate_d;
   logic          start;
   logic          take;
   logic [DW-1:0] mag;

   generate
      if (DW < 4) begin : g_bad_dw
         $error("burst_peak_meter: DW must be at least 4");
      end
   endgenerate

   assign start = gate_i && !gate_d;
   assign take  = gate_i && valid_i;
   assign mag   = sample_i[DW-1] ? (~sample_i + 1'b1) : sample_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gate_d <= 1'b0;
         peak_o <= '0;
         seen_o <= 1'b0;
      end else begin
         gate_d <= gate_i;
         if (start)
            peak_o <= valid_i ? mag : '0;
         else if (take && (mag > peak_o))
            peak_o <= mag;
         if (eol_i)
            seen_o <= take;
         else if (take)
            seen_o <= 1'b1;
      end
   end

   a_r2_peak_covers_sample: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (peak_o >= $past(mag)));
   a_r2_peak_monotone: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_i && !start) |=> (peak_o >= $past(peak_o)));
endmodule

// File: rtl/gain_tracker.sv
module gain_tracker
   import chroma_gain_pkg::*;
#(
   parameter int DW        = 10,
   parameter int GW        = 8,
   parameter int GAIN_MIN  = 16,
   parameter int GAIN_MAX  = 255,
   parameter int GAIN_INIT = 64,
   parameter int DEADBAND  = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          eol_i,
   input  logic          seen_i,
   input  logic          freeze_i,
   input  logic [DW-1:0] peak_i,
   input  logic [DW-1:0] target_i,
   output logic [GW-1:0] gain_o
);
   localparam int            CW    = DW + 2;
   localparam logic [GW-1:0] GMIN  = GW'(GAIN_MIN);
   localparam logic [GW-1:0] GMAX  = GW'(GAIN_MAX);
   localparam logic [GW-1:0] GINIT = GW'(GAIN_INIT);
   localparam logic [CW-1:0] DBW   = CW'(DEADBAND);

   generate
      if (GAIN_MIN > GAIN_INIT || GAIN_INIT > GAIN_MAX || GAIN_MAX >= (1 << GW)) begin : g_bad_range
         $error("gain_tracker: gain limits inconsistent");
      end
   endgenerate

   logic [CW-1:0] peak_w;
   logic [CW-1:0] tgt_w;
   gain_step_e    step;

   assign peak_w = CW'(peak_i);
   assign tgt_w  = CW'(target_i);

   always_comb begin
      if ((peak_w + DBW) < tgt_w)
         step = STEP_UP;
      else if (peak_w > (tgt_w + DBW))
         step = STEP_DOWN;
      else
         step = STEP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gain_o <= GINIT;
      end else if (eol_i && seen_i && !freeze_i) begin
         case (step)
            STEP_UP:   if (gain_o < GMAX) gain_o <= gain_o + 1'b1;
            STEP_DOWN: if (gain_o > GMIN) gain_o <= gain_o - 1'b1;
            default:   gain_o <= gain_o;
         endcase
      end
   end

   a_r3_one_code_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((gain_o == $past(gain_o)) || (gain_o == $past(gain_o) + 1'b1)
                || (gain_o == $past(gain_o) - 1'b1)));
   a_r6_hold_without_eol: assert property (@(posedge clk) disable iff (!rst_n)
      !(eol_i && seen_i) |=> $stable(gain_o));
   a_r7_freeze_in_manual: assert property (@(posedge clk) disable iff (!rst_n)
      freeze_i |=> $stable(gain_o));
   a_r5_gain_bounds: assert property (@(posedge clk) disable iff (!rst_n)
      (gain_o >= GMIN) && (gain_o <= GMAX));
endmodule

// File: rtl/chroma_scaler.sv
module chroma_scaler #(
   parameter int DW    = 10,
   parameter int CW    = 8,
   parameter int CF    = 6,
   parameter bit ROUND = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 valid_i,
   input  logic                 tag_i,
   input  logic signed [DW-1:0] sample_i,
   input  logic [CW-1:0]        coef_i,
   output logic                 valid_o,
   output logic                 tag_o,
   output logic signed [DW-1:0] sample_o
);
   localparam int                   PW    = DW + CW + 2;
   localparam int                   MAXI  = (1 << (DW - 1)) - 1;
   localparam int                   MINI  = -(1 << (DW - 1));
   localparam logic signed [PW-1:0] MAXV  = PW'(MAXI);
   localparam logic signed [PW-1:0] MINV  = PW'(MINI);
   localparam logic signed [PW-1:0] HALF  = PW'(1 << (CF - 1));

   generate
      if (CF < 1 || CF >= CW) begin : g_bad_cf
         $error("chroma_scaler: CF must be between 1 and CW-1");
      end
   endgenerate

   logic signed [PW-1:0] prod;
   logic signed [PW-1:0] rnd;
   logic signed [PW-1:0] shf;
   logic signed [DW-1:0] clip;

   assign prod = PW'(sample_i) * PW'($signed({1'b0, coef_i}));

   generate
      if (ROUND) begin : g_round
         assign rnd = prod + HALF;
      end else begin : g_trunc
         assign rnd = prod;
      end
   endgenerate

   assign shf = rnd >>> CF;

   always_comb begin
      if (shf > MAXV)
         clip = MAXV[DW-1:0];
      else if (shf < MINV)
         clip = MINV[DW-1:0];
      else
         clip = shf[DW-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o  <= 1'b0;
         tag_o    <= 1'b0;
         sample_o <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            tag_o    <= tag_i;
            sample_o <= clip;
         end
      end
   end

   a_r9_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (sample_i == '0)) |=> (sample_o == '0));
   a_r10_zero_coef_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && (coef_i == '0)) |=> (sample_o == '0));
endmodule

// File: rtl/chroma_gain_loop.sv
module chroma_gain_loop #(
   parameter int DW          = 10,
   parameter int GW          = 8,
   parameter int GF          = 6,
   parameter int TW          = 8,
   parameter int TF          = 6,
   parameter int GAIN_MIN    = 16,
   parameter int GAIN_MAX    = 255,
   parameter int GAIN_INIT   = 64,
   parameter int DEADBAND    = 2,
   parameter int REF_DEFAULT = 112,
   parameter bit ROUND       = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_is_v,
   input  logic signed [DW-1:0] chroma_in,
   input  logic                 burst_gate,
   input  logic                 line_end,
   input  logic                 manual_en,
   input  logic [GW-1:0]        manual_gain,
   input  logic [DW-1:0]        target_level,
   input  logic [TW-1:0]        trim_u,
   input  logic [TW-1:0]        trim_v,
   output logic                 out_valid,
   output logic                 out_is_v,
   output logic signed [DW-1:0] chroma_out,
   output logic [GW-1:0]        gain_out
);
   localparam logic [DW-1:0] REF_W = DW'(REF_DEFAULT);

   generate
      if (REF_DEFAULT <= 0 || REF_DEFAULT >= (1 << DW)) begin : g_bad_ref
         $error("chroma_gain_loop: REF_DEFAULT out of range");
      end
   endgenerate

   logic [DW-1:0]        peak;
   logic                 seen;
   logic [DW-1:0]        target_eff;
   logic [GW-1:0]        loop_gain;
   logic                 s1_valid;
   logic                 s1_is_v;
   logic signed [DW-1:0] s1_sample;
   logic [TW-1:0]        trim_sel;

   assign target_eff = (target_level == '0) ? REF_W : target_level;
   assign gain_out   = manual_en ? manual_gain : loop_gain;
   assign trim_sel   = s1_is_v ? trim_v : trim_u;

   burst_peak_meter #(.DW(DW)) u_meter (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (in_valid),
      .sample_i (chroma_in),
      .gate_i   (burst_gate),
      .eol_i    (line_end),
      .peak_o   (peak),
      .seen_o   (seen)
   );

   gain_tracker #(
      .DW(DW), .GW(GW), .GAIN_MIN(GAIN_MIN), .GAIN_MAX(GAIN_MAX),
      .GAIN_INIT(GAIN_INIT), .DEADBAND(DEADBAND)
   ) u_tracker (
      .clk      (clk),
      .rst_n    (rst_n),
      .eol_i    (line_end),
      .seen_i   (seen),
      .freeze_i (manual_en),
      .peak_i   (peak),
      .target_i (target_eff),
      .gain_o   (loop_gain)
   );

   chroma_scaler #(.DW(DW), .CW(GW), .CF(GF), .ROUND(ROUND)) u_gain_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (in_valid),
      .tag_i    (in_is_v),
      .sample_i (chroma_in),
      .coef_i   (gain_out),
      .valid_o  (s1_valid),
      .tag_o    (s1_is_v),
      .sample_o (s1_sample)
   );

   chroma_scaler #(.DW(DW), .CW(TW), .CF(TF), .ROUND(ROUND)) u_trim_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (s1_valid),
      .tag_i    (s1_is_v),
      .sample_i (s1_sample),
      .coef_i   (trim_sel),
      .valid_o  (out_valid),
      .tag_o    (out_is_v),
      .sample_o (chroma_out)
   );

   a_r7_manual_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      manual_en |-> (gain_out == manual_gain));
   a_r9_valid_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
      (s1_valid && !$past(in_valid)) |-> 1'b0);
endmodule

// File: tb/tb_chroma_gain_loop.sv
module tb_chroma_gain_loop;
   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_is_v = 1'b0;
   logic signed [9:0] chroma_in = '0;
   logic              burst_gate = 1'b0;
   logic              line_end = 1'b0;
   logic              manual_en = 1'b0;
   logic [7:0]        manual_gain = 8'd0;
   logic [9:0]        target_level = 10'd112;
   logic [7:0]        trim_u = 8'd64;
   logic [7:0]        trim_v = 8'd64;
   logic              out_valid;
   logic              out_is_v;
   logic signed [9:0] chroma_out;
   logic [7:0]        gain_out;

   typedef struct {
      int    val;
      bit    isv;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_fail = 0;

   int m_gain = 64;
   int m_peak = 0;
   bit m_seen = 1'b0;
   bit m_gate_d = 1'b0;

   always #2 clk = ~clk;

   chroma_gain_loop dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_v(in_is_v),
      .chroma_in(chroma_in), .burst_gate(burst_gate), .line_end(line_end),
      .manual_en(manual_en), .manual_gain(manual_gain), .target_level(target_level),
      .trim_u(trim_u), .trim_v(trim_v), .out_valid(out_valid), .out_is_v(out_is_v),
      .chroma_out(chroma_out), .gain_out(gain_out)
   );

   function automatic int scl(int x, int c);
      int p;
      p = (x * c + 32) >>> 6;
      if (p > 511) p = 511;
      if (p < -512) p = -512;
      return p;
   endfunction

   function automatic int absv(int x);
      return (x < 0) ? -x : x;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // one cycle: drive at negedge, model the edge, return at next negedge
   task automatic drive(bit v, int x, bit isv, bit gate, bit eol, string tag);
      int g;
      int tgt;
      int t;
      bit take;
      in_valid = v; chroma_in = 10'(x); in_is_v = isv; burst_gate = gate; line_end = eol;
      g = manual_en ? int'(manual_gain) : m_gain;
      t = isv ? int'(trim_v) : int'(trim_u);
      if (v) exp_q.push_back('{scl(scl(x, g), t), isv, tag});
      @(negedge clk);
      take = gate && v;
      tgt = (target_level == 0) ? 112 : int'(target_level);
      if (eol && m_seen && !manual_en) begin
         if (m_peak + 2 < tgt) m_gain = (m_gain < 255) ? m_gain + 1 : 255;
         else if (m_peak > tgt + 2) m_gain = (m_gain > 16) ? m_gain - 1 : 16;
      end
      if (gate && !m_gate_d) m_peak = v ? absv(x) : 0;
      else if (take && absv(x) > m_peak) m_peak = absv(x);
      if (eol) m_seen = take;
      else if (take) m_seen = 1'b1;
      m_gate_d = gate;
   endtask

   // a line: burst of alternating +amp/-amp, a few active samples, end strobe
   task automatic run_line(int amp, int nburst, string tag);
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0, tag);
      for (int i = 0; i < nburst; i++)
         drive(1'b1, (i % 2 == 0) ? amp : -amp, i[0], 1'b1, 1'b0, tag);
      drive(1'b1, 37, 1'b0, 1'b0, 1'b0, tag);
      drive(1'b1, -81, 1'b1, 1'b0, 1'b0, tag);
      drive(1'b1, 200, 1'b0, 1'b0, 1'b0, tag);
      drive(1'b0, 0, 1'b0, 1'b0, 1'b1, tag);
   endtask

   task automatic check_gain(int expv, string req);
      check(gain_out == 8'(expv), req, int'(gain_out), expv);
   endtask

   task automatic drain();
      for (int i = 0; i < 4; i++) drive(1'b0, 0, 1'b0, 1'b0, 1'b0, "idle");
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R9 unexpected output", int'(chroma_out), 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(int'(chroma_out) == e.val, {"R9/R10 sample ", e.tag}, int'(chroma_out), e.val);
            check(out_is_v == e.isv, {"R9 tag ", e.tag}, int'(out_is_v), int'(e.isv));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      check_gain(64, "R1 reset gain");
      check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_gain(64, "R1 gain after release");

      run_line(100, 6, "R3 low burst");
      check_gain(65, "R3 up step");
      run_line(115, 6, "R3 high burst");
      check_gain(64, "R3 down step");
      run_line(114, 6, "R4 edge high");
      check_gain(64, "R4 hold at +2");
      run_line(110, 6, "R4 edge low");
      check_gain(64, "R4 hold at -2");
      run_line(109, 6, "R4 outside");
      check_gain(65, "R4 up at -3");

      // R2: negative peak dominates
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0, "R2");
      drive(1'b1, 50, 1'b0, 1'b1, 1'b0, "R2");
      drive(1'b1, -120, 1'b1, 1'b1, 1'b0, "R2");
      drive(1'b1, 30, 1'b0, 1'b1, 1'b0, "R2");
      drive(1'b0, 0, 1'b0, 1'b0, 1'b1, "R2");
      check_gain(64, "R2 absolute peak");

      // R2: new gate window restarts the peak
      drive(1'b1, 300, 1'b0, 1'b1, 1'b0, "R2 restart");
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0, "R2 restart");
      drive(1'b1, 100, 1'b0, 1'b1, 1'b0, "R2 restart");
      drive(1'b0, 0, 1'b0, 1'b0, 1'b1, "R2 restart");
      check_gain(65, "R2 restart per window");

      run_line(0, 0, "R6 no burst");
      check_gain(65, "R6 hold without burst");

      // R7 manual override
      manual_en = 1'b1; manual_gain = 8'd200;
      @(negedge clk);
      check_gain(200, "R7 manual gain");
      run_line(10, 4, "R7 manual scaling");
      check_gain(200, "R7 manual held");
      manual_en = 1'b0;
      @(negedge clk);
      check_gain(65, "R7 loop frozen");

      // R8 target selection
      target_level = 10'd0;
      run_line(100, 4, "R8 default");
      check_gain(66, "R8 default target");
      target_level = 10'd50;
      run_line(100, 4, "R8 programmed");
      check_gain(65, "R8 programmed target");
      target_level = 10'd112;

      // R9 separate trims
      drain();
      trim_u = 8'd32; trim_v = 8'd96;
      drain();
      for (int i = 0; i < 8; i++)
         drive(1'b1, (i * 73) - 250, i[0], 1'b0, 1'b0, "R9 trims");
      drain();
      trim_u = 8'd64; trim_v = 8'd64;
      drain();

      // R10 clipping
      manual_en = 1'b1; manual_gain = 8'd255;
      drive(1'b1, 400, 1'b0, 1'b0, 1'b0, "R10 positive clip");
      drive(1'b1, -500, 1'b1, 1'b0, 1'b0, "R10 negative clip");
      drive(1'b1, -512, 1'b0, 1'b0, 1'b0, "R10 min input");
      drain();
      manual_en = 1'b0;

      // R11 end strobe coincident with gate opening
      run_line(100, 4, "R11 setup");
      check_gain(66, "R11 setup");
      drive(1'b1, 90, 1'b0, 1'b1, 1'b0, "R11");
      drive(1'b0, 0, 1'b0, 1'b0, 1'b0, "R11");
      drive(1'b1, 300, 1'b1, 1'b1, 1'b1, "R11");
      check_gain(67, "R11 decision uses old peak");
      drive(1'b1, 20, 1'b0, 1'b1, 1'b0, "R11");
      drive(1'b0, 0, 1'b0, 1'b0, 1'b1, "R11");
      check_gain(66, "R11 sample counted next line");

      // R5 saturation
      target_level = 10'd511;
      for (int i = 0; i < 200; i++) begin
         drive(1'b1, 0, 1'b0, 1'b1, 1'b0, "R5 up");
         drive(1'b0, 0, 1'b0, 1'b0, 1'b1, "R5 up");
      end
      check_gain(255, "R5 upper limit");
      target_level = 10'd1;
      for (int i = 0; i < 250; i++) begin
         drive(1'b1, 500, 1'b0, 1'b1, 1'b0, "R5 down");
         drive(1'b0, 0, 1'b0, 1'b0, 1'b1, "R5 down");
      end
      check_gain(16, "R5 lower limit");

      drain();
      check(exp_q.size() == 0, "R9 outputs outstanding", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule